// File: doc/BRIEF.md
# Reset Strap Sampler and Boot Selector

This block reads boot straps from a group of shared external address pads while the chip is held in reset. Any of three reset sources (power-on, warm, maximum) restarts the capture. The reset release passes through a two-flop chain, and the straps are frozen on the edge where that chain lets go. While capture is in progress the block turns off the pad output drivers and turns on weak pull-ups and pull-downs, so that a pad nobody drives still reads its default value. When capture ends, the pulls are released and the pads are handed to the external memory controller as address outputs.

The captured 2-bit boot mode drives several decisions: the first-fetch jump target forced on the processor, a mode-dependent vector of module enables, the chip-select 0 assignment, and the enable of a boot-status GPIO. The 4-bit pin-arrangement code is passed on to the memory pin logic in the two modes that use external memory. Both fields can be read back through a read-only configuration word. The forced jump is held until the processor acknowledges its first instruction fetch.

Top module: `boot_strap_ctrl`

## Requirements
- R1: While the synchronised reset is active, the block samples boot mode from pad bits [13:12] and the pin-arrangement code from pad bits [11:8]. The value it keeps is the one present on the pads before the second rising edge after all reset inputs drop.
- R2: During capture, `pull_up_en` is set on pads 11, 10 and 8 and `pull_dn_en` on pads 13, 12 and 9, so undriven pads read boot mode 00 and code 1101. Both pull vectors are zero once capture ends.
- R3: `boot_cfg_rd` returns {code[3:0], mode[1:0]} in bits [5:0] and zeros above. After capture it ignores any later change on the pads.
- R4: During capture `pad_oe` is all zeros. After capture it is all ones and `pad_out` equals `mem_addr`.
- R5: `jump_target` is 0x0000_8000 for modes 00, 10 and 11, and 0x0200_0000 for mode 01.
- R6: `mod_en` bit 0 (external memory) is set for modes 00 and 01. Bit 1 (DMA channel and transfer controllers) is set for 00, 10 and 11. Bit 2 (MMC/SD0) is set only for 10, and bit 3 (UART0) only for 11.
- R7: `cs0_boot` is set for modes 00 and 01 and `stat_gpio_oe` for modes 00, 10 and 11. `pin_cfg_out` carries the code in modes 00 and 01 and is zero otherwise.
- R8: `force_jump` rises at the same edge the decoded outputs become valid. It falls at the edge that samples `fetch_ack` high while it is set. An acknowledge at any other time has no effect.
- R9: Asserting any one of `por_rst`, `warm_rst` or `max_rst` clears `mod_en`, `cs0_boot`, `stat_gpio_oe`, `pin_cfg_out` and `force_jump` within two cycles. It also returns the pads to capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_rst | input | 1 | Power-on reset, active high |
| warm_rst | input | 1 | Warm reset, active high |
| max_rst | input | 1 | Maximum reset, active high |
| pad_in | input | 14 | Pad input levels |
| mem_addr | input | 14 | Address from the memory controller |
| pad_out | output | 14 | Pad output value |
| pad_oe | output | 14 | Pad output enables |
| pull_up_en | output | 14 | Weak pull-up enables |
| pull_dn_en | output | 14 | Weak pull-down enables |
| core_rst | output | 1 | Synchronised reset, high during capture |
| boot_cfg_rd | output | 32 | Read-only boot configuration word |
| fetch_ack | input | 1 | First instruction fetch accepted |
| force_jump | output | 1 | Forced first-fetch jump request |
| jump_target | output | 32 | Forced jump address |
| mod_en | output | 4 | Module enables |
| cs0_boot | output | 1 | Chip select 0 owned by boot device |
| stat_gpio_oe | output | 1 | Boot-status GPIO driven |
| pin_cfg_out | output | 4 | Applied memory pin arrangement |

## Verification
Some properties are checked by assertions on every cycle. The pulls are off whenever the pads drive. The UART and MMC enables never coexist and each matches its mode. The forced jump always points at one of the two legal targets and drops after an accepted acknowledge. The straps stay frozen once capture has ended. The other behaviours need the bench's scenarios. These are the exact capture edge, the pull-default path with undriven pads, the per-mode decode values, restarting from each reset source, and the pads being ignored after handover.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    BOOT_NAND   = 2'b00,
    BOOT_EXTMEM = 2'b01,
    BOOT_MMC    = 2'b10,
    BOOT_UART   = 2'b11
  } boot_mode_e;

  typedef struct packed {
    logic [3:0] pcfg;
    boot_mode_e mode;
  } strap_t;

  localparam logic [31:0] ROM_VECTOR = 32'h0000_8000;
  localparam logic [31:0] EXT_VECTOR = 32'h0200_0000;

  localparam int EN_EXTMEM = 0;
  localparam int EN_DMA    = 1;
  localparam int EN_MMC    = 2;
  localparam int EN_UART   = 3;
  localparam int EN_W      = 4;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import bsc_pkg::*;
#(
  parameter int         ADDR_W   = 14,
  parameter int         MODE_LSB = 12,
  parameter int         PCFG_LSB = 8,
  parameter logic [1:0] DEF_MODE = 2'b00,
  parameter logic [3:0] DEF_PCFG = 4'b1101
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic [ADDR_W-1:0] pad_in,
  output logic              core_rst,
  output strap_t            straps,
  output logic [ADDR_W-1:0] pull_up_en,
  output logic [ADDR_W-1:0] pull_dn_en
);
  localparam logic [ADDR_W-1:0] FIELD_MASK =
    (ADDR_W'(2'b11) << MODE_LSB) | (ADDR_W'(4'hF) << PCFG_LSB);
  localparam logic [ADDR_W-1:0] UP_MASK =
    (ADDR_W'(DEF_MODE) << MODE_LSB) | (ADDR_W'(DEF_PCFG) << PCFG_LSB);
  localparam logic [ADDR_W-1:0] DN_MASK = FIELD_MASK & ~UP_MASK;

  logic sync1, sync2;

  always_ff @(posedge clk) begin
    sync1 <= rst_any;
    sync2 <= sync1 | rst_any;
  end

  always_ff @(posedge clk) begin
    if (sync2) begin
      straps.mode <= boot_mode_e'(pad_in[MODE_LSB +: 2]);
      straps.pcfg <= pad_in[PCFG_LSB +: 4];
    end
  end

  assign core_rst   = sync2;
  assign pull_up_en = sync2 ? UP_MASK : '0;
  assign pull_dn_en = sync2 ? DN_MASK : '0;

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst_any)
    (!core_rst && !$past(core_rst)) |-> $stable(straps));
endmodule

// File: rtl/boot_decode.sv
module boot_decode
  import bsc_pkg::*;
(
  input  logic            clk,
  input  logic            core_rst,
  input  strap_t          straps,
  output logic [31:0]     jump_target,
  output logic [EN_W-1:0] mod_en,
  output logic            cs0_boot,
  output logic            stat_gpio_oe,
  output logic [3:0]      pin_cfg_out
);
  logic            ext_path;
  logic [EN_W-1:0] en_next;

  assign ext_path = (straps.mode == BOOT_NAND) || (straps.mode == BOOT_EXTMEM);

  always_comb begin
    en_next            = '0;
    en_next[EN_EXTMEM] = ext_path;
    en_next[EN_DMA]    = (straps.mode != BOOT_EXTMEM);
    en_next[EN_MMC]    = (straps.mode == BOOT_MMC);
    en_next[EN_UART]   = (straps.mode == BOOT_UART);
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      jump_target  <= ROM_VECTOR;
      mod_en       <= '0;
      cs0_boot     <= 1'b0;
      stat_gpio_oe <= 1'b0;
      pin_cfg_out  <= '0;
    end else begin
      jump_target  <= (straps.mode == BOOT_EXTMEM) ? EXT_VECTOR : ROM_VECTOR;
      mod_en       <= en_next;
      cs0_boot     <= ext_path;
      stat_gpio_oe <= (straps.mode != BOOT_EXTMEM);
      pin_cfg_out  <= ext_path ? straps.pcfg : 4'h0;
    end
  end

  p_uart_mode_r6: assert property (@(posedge clk) disable iff (core_rst)
    mod_en[EN_UART] |-> straps.mode == BOOT_UART);
  p_mmc_uart_excl_r6: assert property (@(posedge clk) disable iff (core_rst)
    $countones(mod_en[EN_UART:EN_MMC]) <= 1);
  p_cs_vs_status_r7: assert property (@(posedge clk) disable iff (core_rst)
    cs0_boot |-> mod_en[EN_EXTMEM]);
endmodule

// File: rtl/fetch_force.sv
module fetch_force (
  input  logic clk,
  input  logic core_rst,
  input  logic fetch_ack,
  output logic force_jump
);
  logic armed;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      armed      <= 1'b1;
      force_jump <= 1'b0;
    end else begin
      if (force_jump && fetch_ack) armed <= 1'b0;
      force_jump <= armed && !(force_jump && fetch_ack);
    end
  end

  p_jump_clear_r8: assert property (@(posedge clk) disable iff (core_rst)
    (force_jump && fetch_ack) |=> !force_jump);
  p_jump_once_r8: assert property (@(posedge clk) disable iff (core_rst)
    (!force_jump && !armed) |=> !force_jump);
endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl
  import bsc_pkg::*;
#(
  parameter int         ADDR_W   = 14,
  parameter int         MODE_LSB = 12,
  parameter int         PCFG_LSB = 8,
  parameter logic [1:0] DEF_MODE = 2'b00,
  parameter logic [3:0] DEF_PCFG = 4'b1101
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic              max_rst,
  input  logic [ADDR_W-1:0] pad_in,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pad_out,
  output logic [ADDR_W-1:0] pad_oe,
  output logic [ADDR_W-1:0] pull_up_en,
  output logic [ADDR_W-1:0] pull_dn_en,
  output logic              core_rst,
  output logic [31:0]       boot_cfg_rd,
  input  logic              fetch_ack,
  output logic              force_jump,
  output logic [31:0]       jump_target,
  output logic [EN_W-1:0]   mod_en,
  output logic              cs0_boot,
  output logic              stat_gpio_oe,
  output logic [3:0]        pin_cfg_out
);
  localparam int CFG_W = $bits(strap_t);

  logic   rst_any;
  strap_t straps;

  assign rst_any = por_rst | warm_rst | max_rst;

  strap_capture #(
    .ADDR_W(ADDR_W), .MODE_LSB(MODE_LSB), .PCFG_LSB(PCFG_LSB),
    .DEF_MODE(DEF_MODE), .DEF_PCFG(DEF_PCFG)
  ) u_cap (
    .clk        (clk),
    .rst_any    (rst_any),
    .pad_in     (pad_in),
    .core_rst   (core_rst),
    .straps     (straps),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en)
  );

  boot_decode u_dec (
    .clk          (clk),
    .core_rst     (core_rst),
    .straps       (straps),
    .jump_target  (jump_target),
    .mod_en       (mod_en),
    .cs0_boot     (cs0_boot),
    .stat_gpio_oe (stat_gpio_oe),
    .pin_cfg_out  (pin_cfg_out)
  );

  fetch_force u_ff (
    .clk        (clk),
    .core_rst   (core_rst),
    .fetch_ack  (fetch_ack),
    .force_jump (force_jump)
  );

  assign pad_oe      = {ADDR_W{~core_rst}};
  assign pad_out     = mem_addr;
  assign boot_cfg_rd = {{(32-CFG_W){1'b0}}, straps};

  p_pull_off_r2: assert property (@(posedge clk) disable iff (rst_any)
    (|pad_oe) |-> (pull_up_en == '0 && pull_dn_en == '0));
  p_target_legal_r5: assert property (@(posedge clk) disable iff (rst_any)
    force_jump |-> (jump_target == ROM_VECTOR || jump_target == EXT_VECTOR));
  p_ext_target_r5: assert property (@(posedge clk) disable iff (rst_any)
    (force_jump && jump_target == EXT_VECTOR) |-> cs0_boot);
endmodule

// File: tb/boot_strap_ctrl_test.sv
module boot_strap_ctrl_test;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic        max_rst = 1'b0;
  logic [13:0] drv_val = '0;
  logic        drv_en = 1'b0;
  logic [13:0] mem_addr = 14'h0;
  logic        fetch_ack = 1'b0;
  logic [13:0] pad_in, pad_out, pad_oe, pull_up_en, pull_dn_en;
  logic        core_rst, force_jump, cs0_boot, stat_gpio_oe;
  logic [31:0] boot_cfg_rd, jump_target;
  logic [3:0]  mod_en, pin_cfg_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign pad_in = drv_en ? drv_val : (pull_up_en & ~pull_dn_en);

  boot_strap_ctrl uut (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .max_rst(max_rst),
    .pad_in(pad_in), .mem_addr(mem_addr), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .core_rst(core_rst),
    .boot_cfg_rd(boot_cfg_rd), .fetch_ack(fetch_ack), .force_jump(force_jump),
    .jump_target(jump_target), .mod_en(mod_en), .cs0_boot(cs0_boot),
    .stat_gpio_oe(stat_gpio_oe), .pin_cfg_out(pin_cfg_out)
  );

  typedef struct packed {
    logic [31:0] tgt;
    logic [3:0]  en;
    logic        cs;
    logic        gpio;
    logic [3:0]  pcfg;
    logic [31:0] cfg;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic [1:0] m, logic [3:0] c);
    exp_t e;
    e.tgt  = (m == 2'b01) ? 32'h0200_0000 : 32'h0000_8000;
    e.en   = {m == 2'b11, m == 2'b10, m != 2'b01, m[1] == 1'b0};
    e.cs   = (m[1] == 1'b0);
    e.gpio = (m != 2'b01);
    e.pcfg = (m[1] == 1'b0) ? c : 4'h0;
    e.cfg  = {26'h0, c, m};
    return e;
  endfunction

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R5 jump_target", jump_target, e.tgt);
        chk("R6 mod_en", 32'(mod_en), 32'(e.en));
        chk("R7 cs0_boot", 32'(cs0_boot), 32'(e.cs));
        chk("R7 stat_gpio_oe", 32'(stat_gpio_oe), 32'(e.gpio));
        chk("R7 pin_cfg_out", 32'(pin_cfg_out), 32'(e.pcfg));
        chk("R1 R3 boot_cfg_rd", boot_cfg_rd, e.cfg);
        chk("R8 force_jump set", 32'(force_jump), 32'd1);
        chk("R4 pad_oe", 32'(pad_oe), 32'h3FFF);
        chk("R2 pulls off", 32'(pull_up_en | pull_dn_en), 32'h0);
      end
    end
  end

  // kind: 0 por, 1 warm, 2 max; drive=0 leaves pads to the pulls
  task automatic boot_case(int kind, bit drive, logic [1:0] m, logic [3:0] c);
    @(negedge clk);
    drv_en  = drive;
    drv_val = {m, c, 8'hA5};
    case (kind)
      0: por_rst = 1'b1;
      1: warm_rst = 1'b1;
      default: max_rst = 1'b1;
    endcase
    repeat (2) @(negedge clk);
    // R9: outputs cleared, pads back in capture mode
    chk("R9 mod_en cleared", 32'(mod_en), 32'h0);
    chk("R9 force_jump cleared", 32'(force_jump), 32'h0);
    chk("R9 cs0_boot cleared", 32'(cs0_boot), 32'h0);
    chk("R4 pad_oe off in capture", 32'(pad_oe), 32'h0);
    chk("R2 pull_up pattern", 32'(pull_up_en), 32'h0D00);
    chk("R2 pull_dn pattern", 32'(pull_dn_en), 32'h3200);
    repeat (2) @(negedge clk);
    por_rst = 1'b0; warm_rst = 1'b0; max_rst = 1'b0;
    exp_q.push_back(model(drive ? m : 2'b00, drive ? c : 4'b1101));
    repeat (2) @(negedge clk);
    // R3: pads now belong to memory; strap changes are ignored
    drv_en  = 1'b1;
    drv_val = ~{m, c, 8'hA5};
    mem_addr = {m, c, 8'h3C};
    repeat (2) @(negedge clk);
    ->chk_ev;
    #1;
    chk("R4 pad_out follows mem_addr", 32'(pad_out), 32'({m, c, 8'h3C}));
    // R8: acknowledge clears the forced jump
    fetch_ack = 1'b1;
    @(negedge clk);
    fetch_ack = 1'b0;
    chk("R8 force_jump cleared by ack", 32'(force_jump), 32'h0);
    fetch_ack = 1'b1;
    repeat (2) @(negedge clk);
    fetch_ack = 1'b0;
    chk("R8 stays clear after extra ack", 32'(force_jump), 32'h0);
  endtask

  // R1 capture edge: a strap change after the second edge following release is not kept
  task automatic edge_case();
    @(negedge clk);
    drv_en = 1'b1; drv_val = {2'b10, 4'h6, 8'h00}; warm_rst = 1'b1;
    repeat (3) @(negedge clk);
    warm_rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    drv_val = {2'b11, 4'h9, 8'h00};
    repeat (3) @(negedge clk);
    chk("R1 capture edge", boot_cfg_rd, {26'h0, 4'h6, 2'b10});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset state core_rst", 32'(core_rst), 32'h1);
    chk("R9 reset state force_jump", 32'(force_jump), 32'h0);
    boot_case(0, 1'b1, 2'b00, 4'h3);
    boot_case(1, 1'b0, 2'b11, 4'h0);
    boot_case(2, 1'b1, 2'b11, 4'hA);
    boot_case(0, 1'b1, 2'b01, 4'h7);
    boot_case(1, 1'b1, 2'b10, 4'hF);
    boot_case(2, 1'b1, 2'b01, 4'h0);
    edge_case();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule